// File: doc/BRIEF.md
# Checkpointed State Keeper with Deferred Output Release

This block protects a small bank of state registers and the data stream that leaves it. A producer writes the live registers and pushes words into an outgoing buffer. The words stay hidden from the consumer until a checkpoint covers them. A checkpoint copies the live registers into a backup bank and makes every buffered word visible on the output stream. The checkpoint is taken when the `ckpt_req` pin is pulsed, or automatically on a programmable cycle interval.

When an error is flagged, the block rolls back in one cycle. The live registers return to the backup copy, and every word written since the last checkpoint is thrown away. Words already committed stay in the buffer and keep draining. Consecutive rollbacks with no checkpoint between them are counted. When the count reaches a parameterised limit, `escalate` is raised so that a stronger recovery action can take over.

Both data interfaces are valid/ready. The input accepts a word only when `in_valid` and `in_ready` are both high. `in_ready` drops while the buffer holds `DEPTH` words, counting committed and uncommitted words alike, so no data is ever dropped. On the output, once `out_valid` is high it and `out_data` hold until `out_ready` takes the word.

Top module: `ckpt_commit_unit`

## Requirements
- R1: After reset, all live and backup registers are zero, `out_valid` and `escalate` are low and `in_ready` is high.
- R2: When `ckpt_req` is high and `err_in` is low at a clock edge, the backup bank takes the live register values from before that edge. Every word accepted before that edge becomes visible on the output. A word accepted in that same cycle stays uncommitted.
- R3: When `err_in` is high at an edge, `live_state` equals the backup bank one cycle later. A register write in that same cycle has no effect.
- R4: A rollback discards every uncommitted word, including a word accepted in the rollback cycle. Committed words are kept and drain in order.
- R5: Only committed words reach the output, in the order they were accepted. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R6: `in_ready` is low exactly while the buffer holds `DEPTH` words. It rises again only when a word leaves or a rollback frees space.
- R7: When `err_in` and a checkpoint (requested or automatic) fall in the same cycle, only the rollback takes effect. Nothing is committed, and the backup bank is unchanged.
- R8: Each rollback increments a saturating counter. `escalate` is high while the counter equals `RETRY_MAX`. A checkpoint that takes effect clears the counter and `escalate` in the next cycle.
- R9: With `ckpt_interval` = N, not zero, an automatic checkpoint fires when N cycles have passed since the last checkpoint slot. Both requested and automatic slots restart the interval count. N = 0 disables automatic checkpoints.
- R10: A write with `st_we` high stores `st_wdata` into register `st_addr`. Register k occupies bits [k*STATE_W +: STATE_W] of `live_state`, and the new value is visible after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_we | input | 1 | Live register write enable |
| st_addr | input | $clog2(NREG) | Live register index |
| st_wdata | input | STATE_W | Live register write value |
| live_state | output | NREG*STATE_W | All live registers, register k at bits k*STATE_W |
| in_valid | input | 1 | Producer word valid |
| in_ready | output | 1 | Buffer can accept a word |
| in_data | input | DATA_W | Producer word |
| out_valid | output | 1 | A committed word is available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | DATA_W | Oldest committed word |
| ckpt_req | input | 1 | Explicit checkpoint request |
| err_in | input | 1 | Error flag, triggers rollback |
| ckpt_interval | input | TMR_W | Automatic checkpoint period in cycles, 0 disables |
| escalate | output | 1 | Retry limit reached |

## Verification
Two functions can fall in the same clock edge: a checkpoint (requested or from the interval timer) and a rollback. A third kind of collision is a producer write or push landing on either one. Random stimulus fires `ckpt_req` and `err_in` independently, so these collisions occur many times. Directed steps also drive both together while uncommitted words and a fresh register write are pending. A bench model applies the rule that the rollback wins, and the bench judges the result from what follows. No pending word may appear on the output, the live registers must show the older backup values, and the retry count must still rise toward `escalate`.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  // Action resolved for the current cycle; rollback outranks commit.
  typedef enum logic [1:0] {
    ACT_IDLE     = 2'd0,
    ACT_COMMIT   = 2'd1,
    ACT_ROLLBACK = 2'd2
  } ckpt_act_e;
endpackage

// File: rtl/ckpt_ctrl.sv
module ckpt_ctrl
  import ckpt_pkg::*;
#(
  parameter int TMR_W     = 12,
  parameter int RETRY_MAX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ckpt_req,
  input  logic             err_in,
  input  logic [TMR_W-1:0] interval,
  output ckpt_act_e        act,
  output logic             escalate
);
  localparam int CNT_W = $clog2(RETRY_MAX + 1);

  logic [TMR_W-1:0] tmr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             auto_fire;
  logic             slot;

  assign auto_fire = (interval != '0) && (tmr_q == interval - 1'b1);
  assign slot      = ckpt_req || auto_fire;
  assign escalate  = (cnt_q == CNT_W'(RETRY_MAX));

  always_comb begin
    if (err_in)    act = ACT_ROLLBACK;
    else if (slot) act = ACT_COMMIT;
    else           act = ACT_IDLE;
  end

  // Interval timer restarts on every checkpoint slot, even one lost to a rollback.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          tmr_q <= '0;
    else if (slot || interval == '0)     tmr_q <= '0;
    else                                 tmr_q <= tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else begin
      case (act)
        ACT_ROLLBACK: if (!escalate) cnt_q <= cnt_q + 1'b1;
        ACT_COMMIT:   cnt_q <= '0;
        default:      cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ckpt_shadow_regs.sv
module ckpt_shadow_regs
  import ckpt_pkg::*;
#(
  parameter int STATE_W = 8,
  parameter int NREG    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ckpt_act_e                  act,
  input  logic                       st_we,
  input  logic [$clog2(NREG)-1:0]    st_addr,
  input  logic [STATE_W-1:0]         st_wdata,
  output logic [NREG*STATE_W-1:0]    live_flat,
  output logic [NREG*STATE_W-1:0]    shadow_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [STATE_W-1:0] live_q;
    logic [STATE_W-1:0] shadow_q;
    logic               hit;

    assign hit = st_we && (st_addr == ($clog2(NREG))'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q   <= '0;
        shadow_q <= '0;
      end else if (act == ACT_ROLLBACK) begin
        live_q <= shadow_q;
      end else begin
        if (act == ACT_COMMIT) shadow_q <= live_q;
        if (hit)               live_q   <= st_wdata;
      end
    end

    assign live_flat[i*STATE_W +: STATE_W]   = live_q;
    assign shadow_flat[i*STATE_W +: STATE_W] = shadow_q;
  end
endmodule

// File: rtl/ckpt_commit_fifo.sv
module ckpt_commit_fifo
  import ckpt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ckpt_act_e         act,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int AW    = $clog2(DEPTH);
  localparam int PTR_W = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, cm_q, rd_q;
  logic [PTR_W-1:0]  level;
  logic              push, pop;

  assign level     = wr_q - rd_q;
  assign in_ready  = (level != PTR_W'(DEPTH));
  assign out_valid = (rd_q != cm_q);
  assign out_data  = mem[rd_q[AW-1:0]];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      cm_q <= '0;
      rd_q <= '0;
    end else begin
      rd_q <= rd_q + PTR_W'(pop);
      case (act)
        ACT_ROLLBACK: wr_q <= cm_q;
        ACT_COMMIT: begin
          cm_q <= wr_q;
          wr_q <= wr_q + PTR_W'(push);
        end
        default: wr_q <= wr_q + PTR_W'(push);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && act != ACT_ROLLBACK) mem[wr_q[AW-1:0]] <= in_data;
  end
endmodule

// File: rtl/ckpt_commit_unit.sv
module ckpt_commit_unit
  import ckpt_pkg::*;
#(
  parameter int STATE_W   = 8,
  parameter int NREG      = 4,
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 8,
  parameter int RETRY_MAX = 3,
  parameter int TMR_W     = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     st_we,
  input  logic [$clog2(NREG)-1:0]  st_addr,
  input  logic [STATE_W-1:0]       st_wdata,
  output logic [NREG*STATE_W-1:0]  live_state,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DATA_W-1:0]        in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [DATA_W-1:0]        out_data,
  input  logic                     ckpt_req,
  input  logic                     err_in,
  input  logic [TMR_W-1:0]         ckpt_interval,
  output logic                     escalate
);
  ckpt_act_e                 act;
  logic [NREG*STATE_W-1:0]   shadow_flat;

  ckpt_ctrl #(.TMR_W(TMR_W), .RETRY_MAX(RETRY_MAX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ckpt_req(ckpt_req), .err_in(err_in),
    .interval(ckpt_interval), .act(act), .escalate(escalate)
  );

  ckpt_shadow_regs #(.STATE_W(STATE_W), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .act(act), .st_we(st_we), .st_addr(st_addr),
    .st_wdata(st_wdata), .live_flat(live_state), .shadow_flat(shadow_flat)
  );

  ckpt_commit_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .act(act), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: rtl/ckpt_commit_chk.sv
module ckpt_commit_chk #(
  parameter int SW = 32,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ckpt_req,
  input logic          err_in,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          escalate,
  input logic [SW-1:0] live_state,
  input logic [SW-1:0] shadow_state
);
  AST_CKPT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_req && !err_in |=> shadow_state == $past(live_state)); // R2

  AST_ROLLBACK_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    err_in |=> live_state == $past(shadow_state)); // R3

  AST_ROLLBACK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
    err_in && !out_valid |=> !out_valid); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5

  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && !out_ready && !err_in |=> !in_ready); // R6

  AST_ESC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_req && !err_in |=> !escalate); // R8
endmodule

bind ckpt_commit_unit ckpt_commit_chk #(.SW(NREG*STATE_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ckpt_req(ckpt_req), .err_in(err_in),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .escalate(escalate), .live_state(live_state),
  .shadow_state(shadow_flat)
);

// File: tb/tb_ckpt_commit_unit.sv
`timescale 1ns/1ps
module tb_ckpt_commit_unit;
  localparam int SW = 8, NR = 4, DW = 8, DEPTH = 8, RMAX = 3, TW = 12;
  localparam int LW = SW * NR;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_we = 0; logic [1:0] st_addr = 0; logic [SW-1:0] st_wdata = 0;
  logic [LW-1:0] live_state;
  logic in_valid = 0, in_ready; logic [DW-1:0] in_data = 0;
  logic out_valid, out_ready = 0; logic [DW-1:0] out_data;
  logic ckpt_req = 0, err_in = 0, escalate;
  logic [TW-1:0] ckpt_interval = 0;

  always #4 clk = ~clk;

  ckpt_commit_unit #(.STATE_W(SW), .NREG(NR), .DATA_W(DW), .DEPTH(DEPTH),
                     .RETRY_MAX(RMAX), .TMR_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .st_we(st_we), .st_addr(st_addr),
    .st_wdata(st_wdata), .live_state(live_state), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .ckpt_req(ckpt_req),
    .err_in(err_in), .ckpt_interval(ckpt_interval), .escalate(escalate));

  int checks = 0, errors = 0;
  logic [LW-1:0] m_live = '0, m_shadow = '0;
  logic [DW-1:0] m_q[$];
  int m_com = 0, m_cnt = 0, m_tmr = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_in_ready(); return m_q.size() < DEPTH; endfunction
  function automatic bit exp_out_valid(); return m_com > 0; endfunction

  task automatic model_update();
    bit pop, push, fire;
    pop  = exp_out_valid() && out_ready;
    push = in_valid && exp_in_ready();
    fire = ckpt_req || (ckpt_interval != 0 && m_tmr == int'(ckpt_interval) - 1);
    m_tmr = (fire || ckpt_interval == 0) ? 0 : m_tmr + 1;
    if (pop) begin void'(m_q.pop_front()); m_com--; end
    if (err_in) begin
      m_live = m_shadow;
      while (m_q.size() > m_com) void'(m_q.pop_back());
      if (m_cnt < RMAX) m_cnt++;
    end else begin
      if (fire) begin m_shadow = m_live; m_com = m_q.size(); m_cnt = 0; end
      if (push) m_q.push_back(in_data);
      if (st_we) m_live[st_addr*SW +: SW] = st_wdata;
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " R6 in_ready"}, 64'(in_ready), 64'(exp_in_ready()));
    chk({tag, " R5 out_valid"}, 64'(out_valid), 64'(exp_out_valid()));
    if (exp_out_valid()) chk({tag, " R5 out_data"}, 64'(out_data), 64'(m_q[0]));
    chk({tag, " R10 live_state"}, 64'(live_state), 64'(m_live));
    chk({tag, " R8 escalate"}, 64'(escalate), 64'(m_cnt >= RMAX));
  endtask

  task automatic step(input string tag);
    @(posedge clk); model_update(); @(negedge clk); compare(tag);
  endtask

  task automatic idle();
    st_we = 0; in_valid = 0; out_ready = 0; ckpt_req = 0; err_in = 0;
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 escalate", 64'(escalate), 64'd0);
    chk("R1 live_state", 64'(live_state), 64'd0);

    // R10: register write
    idle(); st_we = 1; st_addr = 2; st_wdata = 8'hA5; step("R10");
    chk("R10 reg2", 64'(live_state[16 +: 8]), 64'hA5);

    // R2: pushed words stay hidden until a checkpoint
    idle();
    for (int i = 0; i < 3; i++) begin in_valid = 1; in_data = 8'h10 + 8'(i); step("R2 push"); end
    chk("R2 hidden before ckpt", 64'(out_valid), 64'd0);
    idle(); ckpt_req = 1; in_valid = 1; in_data = 8'h77; step("R2 ckpt");
    chk("R2 visible after ckpt", 64'(out_valid), 64'd1);
    chk("R2 first word", 64'(out_data), 64'h10);

    // R3 / R4: rollback restores state and drops the uncommitted word 0x77 and a same-cycle push
    idle(); st_we = 1; st_addr = 0; st_wdata = 8'h3C; step("R3 write");
    idle(); err_in = 1; in_valid = 1; in_data = 8'h88; st_we = 1; st_addr = 1; st_wdata = 8'hFF; step("R3 err");
    chk("R3 restored", 64'(live_state), 64'h00A5_0000);
    idle(); out_ready = 1;
    for (int i = 0; i < 3; i++) begin
      chk("R4 committed order", 64'(out_data), 64'(8'h10 + 8'(i)));
      step("R4 drain");
    end
    chk("R4 uncommitted dropped", 64'(out_valid), 64'd0);

    // R7: error and request together; rollback wins
    idle(); st_we = 1; st_addr = 3; st_wdata = 8'h5A; in_valid = 1; in_data = 8'h99; step("R7 prep");
    idle(); ckpt_req = 1; err_in = 1; step("R7 collide");
    chk("R7 nothing committed", 64'(out_valid), 64'd0);
    chk("R7 state restored", 64'(live_state), 64'h00A5_0000);

    // R8: escalation after RMAX consecutive rollbacks (one already counted above by R7 plus R3 earlier? R2 ckpt cleared, R3 err=1, R7=2)
    idle(); err_in = 1; step("R8 err");
    chk("R8 escalate set", 64'(escalate), 64'd1);
    idle(); err_in = 1; step("R8 saturate");
    chk("R8 escalate held", 64'(escalate), 64'd1);
    idle(); ckpt_req = 1; step("R8 clear");
    chk("R8 escalate cleared", 64'(escalate), 64'd0);

    // R6: fill the buffer with the consumer stalled
    idle(); in_valid = 1;
    for (int i = 0; i < DEPTH + 2; i++) begin
      in_data = 8'h40 + 8'(i); ckpt_req = (i == 3); step("R6 fill");
    end
    chk("R6 full backpressure", 64'(in_ready), 64'd0);
    idle(); ckpt_req = 1; step("R6 commit all");
    idle(); out_ready = 1;
    for (int i = 0; i < DEPTH; i++) begin
      chk("R6 no loss", 64'(out_data), 64'(8'h40 + 8'(i)));
      step("R6 drain");
    end

    // R9: automatic checkpoint every 5 cycles
    idle(); ckpt_interval = 5; in_valid = 1; in_data = 8'hC3; step("R9 push");
    idle(); step("R9 wait");
    for (int i = 0; i < 12; i++) step("R9 auto");
    chk("R9 auto commit", 64'(out_valid), 64'd1);
    chk("R9 auto word", 64'(out_data), 64'hC3);
    idle(); ckpt_interval = 0; out_ready = 1; step("R9 drain");

    // random mix, with and without the interval timer
    for (int i = 0; i < 4000; i++) begin
      ckpt_interval = (i >= 2000) ? TW'(7) : TW'(0);
      st_we     = ($urandom % 10) < 3;
      st_addr   = 2'($urandom);
      st_wdata  = 8'($urandom);
      in_valid  = $urandom % 2;
      in_data   = 8'($urandom);
      out_ready = ($urandom % 3) != 0;
      ckpt_req  = ($urandom % 10) == 0;
      err_in    = ($urandom % 16) == 0;
      step("R7 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule